// File: doc/BRIEF.md
# One-step transparent clock correction rewriter

This block sits on the egress side of one switch port and corrects precision time protocol event messages in flight. Each frame arrives as a byte stream whose byte 0 is the first byte of the time protocol header. With the first byte comes a sideband arrival time, which another port captured from the same local nanosecond counter when the frame began to arrive. The block drives that counter on `now_ns` so that every port stamps against one time base. The counter never needs to agree with any master, because only a difference of two of its readings is used.

When the first byte of a frame is accepted at the output, the block records the departure time. The residence time is departure minus arrival, modulo the counter width. For SYNC and DELAY REQUEST frames, the block adds that residence time, scaled to the correction field's fixed-point format, to the correction value already in the frame. The new value is written back into the outgoing bytes before the frame has finished leaving, so no follow-up message is needed. All other frames, and frames that arrive while the port or global enable is off, pass through byte for byte.

Both stream sides use valid/ready. A byte moves when valid and ready are both high at a rising clock edge. Once `out_valid` is high it stays high, with `out_data` and `out_last` unchanged, until `out_ready` takes the byte. The block holds back output until the 8 correction bytes are buffered. It admits a new frame only after the previous frame has fully drained.

Top module: `tc_corr_updater`

## Requirements
- R1: A frame whose header type nibble (low 4 bits of byte 0) is neither 0 nor 1 leaves with every byte and the `last` marker unchanged and in order.
- R2: For type 0 (SYNC) frames of at least 16 bytes, output bytes 8 to 15 carry (C + (D << 16)) mod 2^64, most significant byte first. C is the big-endian value in input bytes 8 to 15, and D is the residence time in nanoseconds. All other bytes are unchanged.
- R3: Type 1 (DELAY REQUEST) frames of at least 16 bytes are corrected exactly as in R2.
- R4: The arrival time is `in_ts` as sampled with the first accepted input byte. The departure time is `now_ns` in the cycle in which the first output byte is accepted.
- R5: The residence time is (departure − arrival) mod 2^TS_W, so it stays correct when the counter wraps between the two stamps.
- R6: If `glb_en` or `port_en` is low when a frame's first byte is accepted, the frame passes unchanged whatever its type.
- R7: An event frame shorter than 16 bytes passes unchanged.
- R8: No byte of a frame is offered at the output while fewer than 8 of its bytes have been accepted, unless its last byte has been accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R10: While any byte of the previous frame is still inside, `in_ready` is low for the first byte of a new frame, and no byte is dropped or duplicated.
- R11: `now_ns` is 0 in reset and rises by TICK_NS (default 1) every clock after reset, wrapping at 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Device-wide correction enable |
| port_en | input | 1 | Correction enable for this port |
| now_ns | output | TS_W | Local free-running nanosecond counter |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ts | input | TS_W | Arrival time, sampled with byte 0 |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a frame |

## Verification
The assertions take for granted that reset is applied at time zero, that `in_ts` stays stable across a frame's first-byte handshake, and that the true residence time is below 2^TS_W. They also assume a frame's first byte begins the header, with no other encapsulation. The stimulus takes each arrival time from the block's own `now_ns` a few hundred nanoseconds back, or from a point just below the wrap, so every residence stays far inside the counter range. Each frame ends with `in_last`, and no input is presented before reset is released.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // Correction field placement inside the header (fixed by the message layout)
  localparam int CF_OFS    = 8;
  localparam int CF_BYTES  = 8;
  localparam int CF_END    = CF_OFS + CF_BYTES;   // first offset past the field
  localparam int CF_IDX_W  = $clog2(CF_BYTES);
  localparam int CF_SCALE  = 16;                   // fractional nanosecond bits
  localparam int CF_W      = 8 * CF_BYTES;

  typedef enum logic [3:0] {
    MSG_SYNC = 4'd0,
    MSG_DREQ = 4'd1
  } evt_msg_e;
endpackage

// File: rtl/tc_timebase.sv
module tc_timebase #(
  parameter int TS_W    = 32,
  parameter int TICK_NS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now_ns
);
  localparam logic [TS_W-1:0] STEP = TS_W'(TICK_NS);

  always_ff @(posedge clk) begin
    if (!rst_n) now_ns <= '0;
    else        now_ns <= now_ns + STEP;
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now_ns == $past(now_ns) + STEP); // R11
endmodule

// File: rtl/tc_lag_fifo.sv
module tc_lag_fifo #(
  parameter int DEPTH = 16,
  parameter int HOLD  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       last_held
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HOLD_CNT = (AW+1)'(HOLD);

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          in_fire, out_fire;

  assign in_ready  = (count != FULL_CNT) && !(frame_start && count != '0);
  assign out_valid = (count != '0) && (count >= HOLD_CNT || last_held);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign out_data  = mem[rd_ptr][7:0];
  assign out_last  = mem[rd_ptr][8];

  always_ff @(posedge clk) begin
    if (in_fire) mem[wr_ptr] <= {in_last, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      last_held <= 1'b0;
    end else begin
      if (in_fire)  wr_ptr <= wr_ptr + 1'b1;
      if (out_fire) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(in_fire) - (AW+1)'(out_fire);
      if (in_fire && in_last)        last_held <= 1'b1;
      else if (out_fire && out_last) last_held <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R10
endmodule

// File: rtl/tc_cf_sum.sv
module tc_cf_sum import tc_pkg::*; #(
  parameter int TS_W = 32
) (
  input  logic [CF_W-1:0]     cf_orig,
  input  logic [TS_W-1:0]     arr_ts,
  input  logic [TS_W-1:0]     dep_ts,
  input  logic [CF_IDX_W-1:0] sel,
  output logic [7:0]          sum_byte
);
  logic [TS_W-1:0] resid;
  logic [CF_W-1:0] resid_fx;
  logic [CF_W-1:0] cf_new;
  logic [7:0]      bytes_be [CF_BYTES];

  assign resid    = dep_ts - arr_ts;
  assign resid_fx = {{(CF_W-TS_W){1'b0}}, resid} << CF_SCALE;
  assign cf_new   = cf_orig + resid_fx;

  for (genvar b = 0; b < CF_BYTES; b++) begin : g_be
    assign bytes_be[b] = cf_new[8*(CF_BYTES-1-b) +: 8];
  end

  assign sum_byte = bytes_be[sel];
endmodule

// File: rtl/tc_corr_updater.sv
module tc_corr_updater import tc_pkg::*; #(
  parameter int TS_W    = 32,
  parameter int TICK_NS = 1,
  parameter int DEPTH   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glb_en,
  input  logic            port_en,
  output logic [TS_W-1:0] now_ns,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  input  logic [TS_W-1:0] in_ts,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            out_last
);
  localparam int OFF_W = $clog2(CF_END) + 1;
  localparam logic [OFF_W-1:0] OFF_CF  = OFF_W'(CF_OFS);
  localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(CF_END);
  localparam logic [OFF_W-1:0] OFF_TOP = OFF_W'(CF_END - 1);

  logic [OFF_W-1:0]    in_off, out_off;
  logic                frame_start, in_fire, out_fire;
  logic [3:0]          mtype;
  logic                en_frm, cf_full;
  logic [CF_W-1:0]     cf_orig;
  logic [TS_W-1:0]     arr_ts, dep_ts;
  logic [7:0]          head_data, sum_byte;
  logic                head_last, last_held;
  logic                is_evt, in_win, fix;
  logic [CF_IDX_W-1:0] sel;

  tc_timebase #(.TS_W(TS_W), .TICK_NS(TICK_NS)) u_tb (
    .clk(clk), .rst_n(rst_n), .now_ns(now_ns)
  );

  assign frame_start = (in_off == '0);

  tc_lag_fifo #(.DEPTH(DEPTH), .HOLD(CF_BYTES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(head_data),
    .out_last(head_last), .last_held(last_held)
  );

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  // Input side: header capture for the frame being admitted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_off  <= '0;
      mtype   <= '0;
      en_frm  <= 1'b0;
      cf_full <= 1'b0;
      cf_orig <= '0;
      arr_ts  <= '0;
    end else if (in_fire) begin
      if (in_last)               in_off <= '0;
      else if (in_off != OFF_SAT) in_off <= in_off + 1'b1;
      if (frame_start) begin
        mtype   <= in_data[3:0];
        en_frm  <= glb_en && port_en;
        arr_ts  <= in_ts;
        cf_full <= 1'b0;
      end
      if (in_off >= OFF_CF && in_off < OFF_SAT)
        cf_orig <= {cf_orig[CF_W-9:0], in_data};
      if (in_off == OFF_TOP) cf_full <= 1'b1;
    end
  end

  // Output side: departure stamp and position tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_off <= '0;
      dep_ts  <= '0;
    end else if (out_fire) begin
      if (out_off == '0) dep_ts <= now_ns;
      if (head_last)               out_off <= '0;
      else if (out_off != OFF_SAT) out_off <= out_off + 1'b1;
    end
  end

  assign sel = CF_IDX_W'(out_off - OFF_CF);

  tc_cf_sum #(.TS_W(TS_W)) u_sum (
    .cf_orig(cf_orig), .arr_ts(arr_ts), .dep_ts(dep_ts),
    .sel(sel), .sum_byte(sum_byte)
  );

  assign is_evt   = (mtype == MSG_SYNC) || (mtype == MSG_DREQ);
  assign in_win   = (out_off >= OFF_CF) && (out_off < OFF_SAT);
  assign fix      = en_frm && cf_full && is_evt && in_win;
  assign out_data = fix ? sum_byte : head_data;
  assign out_last = head_last;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R9
  AST_DEP_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_off == '0 |=> dep_ts == $past(now_ns)); // R4
  AST_CF_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_off == OFF_CF && !last_held |-> cf_full); // R2
endmodule

// File: tb/tb_tc_corr_updater.sv
`timescale 1ns/1ps
module tb_tc_corr_updater;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b1, port_en = 1'b1;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic [31:0] in_ts = '0;
  wire  [31:0] now_ns;
  wire         in_ready, out_valid, out_last;
  wire  [7:0]  out_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] fb [64];
  logic [7:0] got [64];
  int flen;

  always #5 clk = ~clk;

  tc_corr_updater dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .port_en(port_en), .now_ns(now_ns),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_ts(in_ts), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic mk_frame(input logic [3:0] mt, input int len, input logic [63:0] cf);
    flen = len;
    for (int i = 0; i < len; i++) fb[i] = 8'((i * 7 + 3) & 8'hff);
    fb[0] = {4'hA, mt};
    for (int i = 0; i < 8; i++) if (8 + i < len) fb[8+i] = cf[8*(7-i) +: 8];
  endtask

  task automatic drive(input logic [31:0] ts, input int gap_at, input int gap_cyc);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == flen - 1); in_ts = ts;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      if (i == gap_at) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap_cyc) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R8", "early release", 64'(out_valid), 64'd0);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic collect(input bit stall, output int n, output logic [31:0] eg);
    logic       pv, pr, pl;
    logic [7:0] pd;
    int k;
    n = 0; k = 0; pv = 0; pr = 1; pd = '0; pl = 0; eg = '0;
    forever begin
      @(negedge clk);
      out_ready = stall ? ((k % 3) != 0) : 1'b1;
      k++;
      #1;
      if (pv && !pr)
        check(out_valid && out_data == pd && out_last == pl, "R9", "stall hold",
              {out_valid, out_data}, {1'b1, pd});
      pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
      if (out_valid && out_ready) begin
        if (n == 0) eg = now_ns;
        got[n] = out_data;
        n++;
        if (out_last || n == 64) break;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic compare(input string req, input int n, input logic [31:0] ts,
                         input logic [31:0] eg, input bit fix);
    logic [7:0]  exp [64];
    logic [63:0] cf;
    int bad_at;
    for (int i = 0; i < flen; i++) exp[i] = fb[i];
    if (fix) begin
      cf = '0;
      for (int i = 8; i < 16; i++) cf = {cf[55:0], fb[i]};
      cf = cf + ({32'd0, eg - ts} << 16);
      for (int i = 0; i < 8; i++) exp[8+i] = cf[8*(7-i) +: 8];
    end
    check(n == flen, req, "frame length", 64'(n), 64'(flen));
    bad_at = -1;
    for (int i = 0; i < flen && i < n; i++) if (got[i] !== exp[i] && bad_at < 0) bad_at = i;
    if (bad_at < 0) check(1'b1, req, "bytes", 0, 0);
    else check(1'b0, req, $sformatf("byte %0d", bad_at), 64'(got[bad_at]), 64'(exp[bad_at]));
  endtask

  task automatic run_frame(input string req, input logic [31:0] ts, input bit stall,
                           input int gap_at, input int gap_cyc, input bit fix);
    int n;
    logic [31:0] eg;
    fork
      drive(ts, gap_at, gap_cyc);
      collect(stall, n, eg);
    join
    compare(req, n, ts, eg, fix);
  endtask

  task automatic t_reset;
    logic [31:0] t0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 0);
    check(now_ns == 32'd0, "R11", "now_ns in reset", 64'(now_ns), 0);
    check(in_ready == 1'b1, "R10", "in_ready idle", 64'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t0 = now_ns;
    repeat (5) @(negedge clk);
    #1;
    check(now_ns - t0 == 32'd5, "R11", "tick", 64'(now_ns - t0), 5);
  endtask

  task automatic t_sync;       // R2 R4
    mk_frame(4'd0, 24, 64'h0000_0000_1234_0000);
    run_frame("R2", now_ns - 32'd200, 0, -1, 0, 1);
  endtask

  task automatic t_dreq_stall; // R3 R9
    mk_frame(4'd1, 20, 64'h0000_0001_0000_8000);
    run_frame("R3", now_ns - 32'd350, 1, -1, 0, 1);
  endtask

  task automatic t_general;    // R1
    mk_frame(4'd8, 22, 64'h1111_2222_3333_4444);
    run_frame("R1", now_ns - 32'd100, 0, -1, 0, 0);
    mk_frame(4'd9, 18, 64'h5555_6666_7777_8888);
    run_frame("R1", now_ns - 32'd100, 1, -1, 0, 0);
    mk_frame(4'hB, 30, 64'h0);
    run_frame("R1", now_ns - 32'd100, 0, -1, 0, 0);
  endtask

  task automatic t_disabled;   // R6
    glb_en = 1'b0;
    mk_frame(4'd0, 20, 64'h0000_0000_0000_0100);
    run_frame("R6", now_ns - 32'd50, 0, -1, 0, 0);
    glb_en = 1'b1; port_en = 1'b0;
    mk_frame(4'd1, 20, 64'h0000_0000_0000_0100);
    run_frame("R6", now_ns - 32'd50, 0, -1, 0, 0);
    port_en = 1'b1;
  endtask

  task automatic t_carry;      // R2 carry across every byte and 64-bit wrap
    mk_frame(4'd0, 16, 64'hFFFF_FFFF_FFFF_FFFF);
    run_frame("R2", now_ns - 32'd77, 0, -1, 0, 1);
  endtask

  task automatic t_wrap;       // R5
    mk_frame(4'd1, 20, 64'h0000_0000_0000_0000);
    run_frame("R5", 32'hFFFF_FF00, 0, -1, 0, 1);
  endtask

  task automatic t_short;      // R7
    mk_frame(4'd0, 12, 64'hAAAA_BBBB_0000_0000);
    run_frame("R7", now_ns - 32'd40, 0, -1, 0, 0);
  endtask

  task automatic t_holdback;   // R8 (7 bytes in, then pause)
    mk_frame(4'd0, 20, 64'h0000_0000_0042_0000);
    run_frame("R8", now_ns - 32'd60, 0, 6, 12, 1);
  endtask

  task automatic t_admit;      // R10
    int n;
    logic [31:0] eg;
    mk_frame(4'd8, 10, 64'h0);
    out_ready = 1'b0;
    drive(now_ns, -1, 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h01; in_last = 1'b0;
    #1;
    check(in_ready == 1'b0, "R10", "new frame admitted early", 64'(in_ready), 0);
    check(out_valid == 1'b1, "R10", "held frame offered", 64'(out_valid), 1);
    in_valid = 1'b0;
    collect(0, n, eg);
    compare("R10", n, 0, eg, 0);
    #1;
    check(in_ready == 1'b1, "R10", "ready after drain", 64'(in_ready), 1);
  endtask

  initial begin
    t_reset();
    t_sync();
    t_dreq_stall();
    t_general();
    t_disabled();
    t_carry();
    t_wrap();
    t_short();
    t_holdback();
    t_admit();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule